// File: doc/BRIEF.md
# UART FIFO Interrupt Controller

This block is the interrupt and status front end that sits beside a UART's receive and transmit FIFOs. Each FIFO holds up to 128 bytes. The serial engine supplies both occupancy counts and several one-cycle event strobes: a break was seen, a character was written into the receive FIFO, a character was popped from it, and one character time has elapsed. From these the block keeps four pending interrupt sources and drives a single interrupt line. It also exposes a small word-addressed register bus for enables, write-one-to-clear, masked status, occupancy, thresholds and a control word.

Two of the sources are threshold comparisons. Receive-full holds while the receive count is at or above its threshold. Transmit-empty holds while the transmit count is at or below its threshold. The break source is an event latch. The receive-timeout source comes from a counter of character times. It counts only while the receive FIFO holds data and nothing arrives or is read.

The register bus is plain, with no flow control. A write is taken on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state. Reads have no side effects. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the enable word reads 0, the threshold word reads 0x0000_4040 (receive threshold 64 in bits 6:0, transmit threshold 64 in bits 14:8), the control word reads 0, the masked status reads 0 and `irq` is low.
- R2: The occupancy word at offset 0x0C reads the receive count in bits 7:0 and the transmit count in bits 15:8, with all other bits zero.
- R3: The receive-full source (bit 0) becomes pending on the edge after the receive count is greater than or equal to the receive threshold.
- R4: The transmit-empty source (bit 1) becomes pending on the edge after the transmit count is less than or equal to the transmit threshold.
- R5: A one-cycle pulse on `brk_evt` sets the break source (bit 7). It stays pending until it is cleared.
- R6: While the receive FIFO is non-empty, the timeout source (bit 13) fires on the `char_tick` that brings the idle count up to the control field in bits 13:9. The counter then saturates and does not fire again. A field of zero, or an empty FIFO, never fires.
- R7: A pulse on `rx_char_evt` or `rx_pop_evt` restarts the idle count from zero.
- R8: A write to the clear word at offset 0x04 clears each pending source whose bit is 1. If a source's set condition is true in the same cycle, the set wins and the source stays pending. Writing all ones clears every source whose condition is false.
- R9: The masked status word at offset 0x08 reads pending AND enable at bits 0, 1, 7 and 13. `irq` is high exactly when that word is nonzero.
- R10: The control word at offset 0x14 stores bits 15:9 only. Bit 15 drives `dma_en` and bit 14 drives `loopback_en`.
- R11: The enable word at offset 0x00 stores only bits 0, 1, 7 and 13. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| rx_level | input | 8 | Receive FIFO occupancy |
| tx_level | input | 8 | Transmit FIFO occupancy |
| brk_evt | input | 1 | Break seen, one-cycle pulse |
| rx_char_evt | input | 1 | Character written into the receive FIFO |
| rx_pop_evt | input | 1 | Character read from the receive FIFO |
| char_tick | input | 1 | One character time elapsed |
| irq | output | 1 | Interrupt request |
| dma_en | output | 1 | DMA enable control bit |
| loopback_en | output | 1 | Loopback enable control bit |

## Verification
The threshold sources are driven at counts one below, equal to and beyond each threshold. This separates a `>=` compare from a `>` compare and a `<=` compare from a `<` compare. Clears are issued both while a set condition persists and after it has lapsed, which shows whether set or clear wins. The timeout is driven with tick runs that stop one short of the threshold, with restarts by arrival and by pop, with a zero threshold and with an empty FIFO. This tells restart, saturation and gating apart.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 4;
  localparam logic [5:0] A_EN  = 6'h00;
  localparam logic [5:0] A_CLR = 6'h04;
  localparam logic [5:0] A_MST = 6'h08;
  localparam logic [5:0] A_LVL = 6'h0C;
  localparam logic [5:0] A_THR = 6'h10;
  localparam logic [5:0] A_CTL = 6'h14;
  // source index -> shared bit position in enable/clear/status words
  function automatic int src_pos(input int i);
    case (i)
      0:       return 0;   // receive-full
      1:       return 1;   // transmit-empty
      2:       return 7;   // break
      default: return 13;  // receive-timeout
    endcase
  endfunction
endpackage

// File: rtl/uirq_pend_bit.sv
module uirq_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/uirq_rx_timer.sv
module uirq_rx_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nonempty,
  input  logic          restart,
  input  logic          tick,
  input  logic [TW-1:0] thr,
  output logic          fire
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign fire = nonempty && !restart && tick && (thr != '0)
                && (cnt_inc == {1'b0, thr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (restart || !nonempty) cnt_q <= '0;
    else if (tick && cnt_q != thr) cnt_q <= cnt_inc[TW-1:0];
  end
endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int LVL_W = 8,
  parameter int THR_W = 7,
  parameter int TO_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [NSRC-1:0]  pend,
  output logic [NSRC-1:0]  en,
  output logic [NSRC-1:0]  clr,
  output logic [THR_W-1:0] rx_thr,
  output logic [THR_W-1:0] tx_thr,
  output logic [TO_W-1:0]  to_thr,
  output logic             dma_en,
  output logic             loopback_en
);
  localparam logic [THR_W-1:0] THR_RST = THR_W'(64);
  localparam int TO_LSB = 9;

  logic wr_en, wr_clr, wr_thr, wr_ctl;
  logic [DW-1:0] en_word, mst_word;

  assign wr_en  = bus_wr && bus_addr == A_EN;
  assign wr_clr = bus_wr && bus_addr == A_CLR;
  assign wr_thr = bus_wr && bus_addr == A_THR;
  assign wr_ctl = bus_wr && bus_addr == A_CTL;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int P = src_pos(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en[i] <= 1'b0;
      else if (wr_en) en[i] <= bus_wdata[P];
    end
    assign clr[i] = wr_clr && bus_wdata[P];
  end

  always_comb begin
    en_word  = '0;
    mst_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      en_word[src_pos(i)]  = en[i];
      mst_word[src_pos(i)] = en[i] & pend[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr      <= THR_RST;
      tx_thr      <= THR_RST;
      to_thr      <= '0;
      dma_en      <= 1'b0;
      loopback_en <= 1'b0;
    end else begin
      if (wr_thr) begin
        rx_thr <= bus_wdata[THR_W-1:0];
        tx_thr <= bus_wdata[8 +: THR_W];
      end
      if (wr_ctl) begin
        dma_en      <= bus_wdata[15];
        loopback_en <= bus_wdata[14];
        to_thr      <= bus_wdata[TO_LSB +: TO_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_EN:  bus_rdata = en_word;
      A_MST: bus_rdata = mst_word;
      A_LVL: begin
        bus_rdata[LVL_W-1:0]     = rx_level;
        bus_rdata[8 +: LVL_W]    = tx_level;
      end
      A_THR: begin
        bus_rdata[THR_W-1:0]     = rx_thr;
        bus_rdata[8 +: THR_W]    = tx_thr;
      end
      A_CTL: begin
        bus_rdata[15]            = dma_en;
        bus_rdata[14]            = loopback_en;
        bus_rdata[TO_LSB +: TO_W] = to_thr;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int LVL_W = 8,
  parameter int THR_W = 7,
  parameter int TO_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             brk_evt,
  input  logic             rx_char_evt,
  input  logic             rx_pop_evt,
  input  logic             char_tick,
  output logic             irq,
  output logic             dma_en,
  output logic             loopback_en
);
  logic [NSRC-1:0]  pend_q, en_q, clr_v, set_v;
  logic [THR_W-1:0] rx_thr_q, tx_thr_q;
  logic [TO_W-1:0]  to_thr_q;
  logic             to_fire;

  uirq_regs #(.DW(DW), .AW(AW), .LVL_W(LVL_W), .THR_W(THR_W), .TO_W(TO_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_level(rx_level),
    .tx_level(tx_level), .pend(pend_q), .en(en_q), .clr(clr_v),
    .rx_thr(rx_thr_q), .tx_thr(tx_thr_q), .to_thr(to_thr_q),
    .dma_en(dma_en), .loopback_en(loopback_en)
  );

  uirq_rx_timer #(.TW(TO_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .nonempty(rx_level != '0),
    .restart(rx_char_evt || rx_pop_evt), .tick(char_tick),
    .thr(to_thr_q), .fire(to_fire)
  );

  assign set_v[0] = rx_level >= LVL_W'(rx_thr_q);
  assign set_v[1] = tx_level <= LVL_W'(tx_thr_q);
  assign set_v[2] = brk_evt;
  assign set_v[3] = to_fire;

  for (genvar i = 0; i < NSRC; i++) begin : g_pend
    uirq_pend_bit pend_i (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]), .q(pend_q[i])
    );
  end

  assign irq = |(pend_q & en_q);
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk
  import uirq_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int THR_W = 7,
  parameter int TO_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [5:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             brk_evt,
  input logic             irq,
  input logic             dma_en,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  en,
  input logic [THR_W-1:0] rx_thr,
  input logic [THR_W-1:0] tx_thr,
  input logic [TO_W-1:0]  to_thr,
  input logic             to_fire
);
  assert_rxfull_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= LVL_W'(rx_thr)) |=> pend[0]);

  assert_txempty_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(tx_thr)) |=> pend[1]);

  assert_brk_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> pend[2]);

  assert_brk_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[2] && !(bus_wr && bus_addr == A_CLR && bus_wdata[7])) |=> pend[2]);

  assert_tout_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (to_thr == '0 || rx_level == '0) |-> !to_fire);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  assert_dma_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTL) |=> dma_en == $past(bus_wdata[15]));
endmodule

bind uirq_ctrl uirq_ctrl_chk #(.LVL_W(LVL_W), .THR_W(THR_W), .TO_W(TO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rx_level(rx_level), .tx_level(tx_level),
  .brk_evt(brk_evt), .irq(irq), .dma_en(dma_en), .pend(pend_q), .en(en_q),
  .rx_thr(rx_thr_q), .tx_thr(tx_thr_q), .to_thr(to_thr_q), .to_fire(to_fire)
);

// File: tb/uirq_ctrl_tb_top.sv
module uirq_ctrl_tb_top;
  import uirq_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_level = '0, tx_level = '0;
  logic        brk_evt = 1'b0, rx_char_evt = 1'b0, rx_pop_evt = 1'b0, char_tick = 1'b0;
  logic        irq, dma_en, loopback_en;

  uirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_level(rx_level),
    .tx_level(tx_level), .brk_evt(brk_evt), .rx_char_evt(rx_char_evt),
    .rx_pop_evt(rx_pop_evt), .char_tick(char_tick), .irq(irq),
    .dma_en(dma_en), .loopback_en(loopback_en)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_go = 1'b0;

  // scoreboard monitor: compares each queued expected read value
  always @(negedge clk) begin
    #4;
    if (rd_go && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_go = 1'b1;
    @(negedge clk);
    rd_go = 1'b0;
  endtask

  // which: 0 irq, 1 dma_en, 2 loopback_en
  task automatic pin(input int which, input logic e, input string tag);
    logic a;
    @(negedge clk);
    #4;
    a = (which == 0) ? irq : (which == 1) ? dma_en : loopback_en;
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, a, e);
    end
  endtask

  task automatic lv(input logic [7:0] r, input logic [7:0] t);
    @(negedge clk);
    rx_level = r; tx_level = t;
  endtask

  // which: 0 brk, 1 rx char, 2 rx pop
  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) brk_evt = 1'b1;
    else if (which == 1) rx_char_evt = 1'b1;
    else rx_pop_evt = 1'b1;
    @(negedge clk);
    brk_evt = 1'b0; rx_char_evt = 1'b0; rx_pop_evt = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    char_tick = 1'b1;
    repeat (n) @(negedge clk);
    char_tick = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    pin(0, 1'b0, "R1 irq");
    rd(A_EN,  32'h0, "R1 enable");
    rd(A_THR, 32'h0000_4040, "R1 thresholds");
    rd(A_CTL, 32'h0, "R1 control");
    rd(A_MST, 32'h0, "R1 masked status");
    // R11 enable width, R9 masking
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, 32'h0000_2083, "R11 enable bits");
    rd(A_MST, 32'h0000_0002, "R9 masked tx-empty");
    pin(0, 1'b1, "R9 irq high");
    wr(A_EN, 32'h0);
    pin(0, 1'b0, "R9 irq low");
    // R4 / R8
    wr(A_EN, 32'h2);
    lv(8'd0, 8'd64);
    rd(A_MST, 32'h2, "R4 tx at threshold");
    lv(8'd0, 8'd65);
    wr(A_CLR, 32'h2);
    rd(A_MST, 32'h0, "R8 clear after condition lapses");
    pin(0, 1'b0, "R9 irq after clear");
    lv(8'd0, 8'd64);
    rd(A_MST, 32'h2, "R4 tx back to threshold");
    wr(A_CLR, 32'h2);
    rd(A_MST, 32'h2, "R8 set wins over clear");
    lv(8'd0, 8'd100);
    wr(A_CLR, 32'h2);
    // R3
    wr(A_THR, 32'h0000_400A);
    wr(A_EN, 32'h1);
    lv(8'd9, 8'd100);
    rd(A_MST, 32'h0, "R3 rx one below threshold");
    lv(8'd10, 8'd100);
    rd(A_MST, 32'h1, "R3 rx at threshold");
    pin(0, 1'b1, "R3 irq");
    // R2
    lv(8'h80, 8'h25);
    rd(A_LVL, 32'h0000_2580, "R2 occupancy");
    lv(8'd0, 8'd100);
    wr(A_CLR, 32'h1);
    rd(A_MST, 32'h0, "R3 cleared");
    // R5
    wr(A_EN, 32'h80);
    pulse(0);
    rd(A_MST, 32'h80, "R5 break set");
    repeat (5) @(negedge clk);
    rd(A_MST, 32'h80, "R5 break sticky");
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_MST, 32'h0, "R8 all-ones clear");
    pin(0, 1'b0, "R9 irq idle");
    // R6 / R7
    wr(A_CTL, 32'h0000_0600);
    wr(A_EN, 32'h2000);
    lv(8'd5, 8'd100);
    ticks(2);
    rd(A_MST, 32'h0, "R6 two ticks of three");
    pulse(1);
    ticks(2);
    rd(A_MST, 32'h0, "R7 restart on arrival");
    ticks(1);
    rd(A_MST, 32'h2000, "R6 timeout fires");
    wr(A_CLR, 32'h2000);
    rd(A_MST, 32'h0, "R6 timeout cleared");
    ticks(3);
    rd(A_MST, 32'h0, "R6 saturated no refire");
    pulse(2);
    ticks(2);
    rd(A_MST, 32'h0, "R7 restart on pop");
    ticks(1);
    rd(A_MST, 32'h2000, "R7 fires after pop restart");
    wr(A_CLR, 32'h2000);
    wr(A_CTL, 32'h0);
    pulse(1);
    ticks(5);
    rd(A_MST, 32'h0, "R6 zero threshold disabled");
    lv(8'd0, 8'd100);
    wr(A_CTL, 32'h0000_0600);
    ticks(4);
    rd(A_MST, 32'h0, "R6 empty fifo no timeout");
    // R10
    wr(A_CTL, 32'h0000_C600);
    pin(1, 1'b1, "R10 dma on");
    pin(2, 1'b1, "R10 loopback on");
    rd(A_CTL, 32'h0000_C600, "R10 control readback");
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, 32'h0000_FE00, "R10 control width");
    wr(A_CTL, 32'h0000_4000);
    pin(1, 1'b0, "R10 dma off");
    pin(2, 1'b1, "R10 loopback kept");
    rd(A_CLR, 32'h0, "R8 clear word reads zero");
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule